// File: doc/BRIEF.md
# Monotonic Protection Register for a Data Memory

This block guards a small nonvolatile data memory against program and erase commands. It holds one 8-bit protection control register and a sticky violation flag, and it judges every command that the memory's command sequencer presents. While reset is asserted the register reads as full protection. The first load-done strobe after reset copies a configuration byte, fetched from program memory, into the register. If that fetch reports an uncorrectable error, full protection is used instead.

After the load, software may only tighten protection. The open bit can be cleared but never set again. The size field can only grow. While the open bit is 0, a window at the top of the memory is protected. The window holds (size + 1) × 64 bytes and never exceeds the whole memory. Each command gets an accept or reject result one cycle after it is presented. A rejection also raises the violation flag, and software clears that flag by writing 1 to it.

Top module: `nvm_prot_guard`

## Requirements
- R1: Register address 0 reads bit 7 = open, bits 4:0 = size, and bits 6:5 as 0. From reset until the first load-done strobe, the register reads 0x1F. In that period, software writes to either address have no effect.
- R2: On the first cycle with cfg_done high after reset, and with cfg_dbe low, the open bit takes cfg_byte bit 7 and the size field takes cfg_byte bits 4:0. Later strobes have no effect.
- R3: If cfg_dbe is high on that first load cycle, the register becomes open = 0 with the size field all ones, whatever cfg_byte holds.
- R4: A write to address 0 after the load leaves open as (old open AND written bit 7). A 0 can never become 1.
- R5: A write to address 0 after the load replaces the size field only if the written bits 4:0 are strictly greater than the current size. Otherwise the size field is unchanged.
- R6: With open = 0, a byte address a is protected when a ≥ MEM_BYTES − min((size + 1) × GRAN_BYTES, MEM_BYTES). With open = 1, no address is protected.
- R7: cmd_kind 2'b00 (program) is accepted if and only if cmd_addr is not protected. res_valid is high, together with the result on res_ok, exactly in the cycle after the cycle with cmd_valid high.
- R8: cmd_kind 2'b01 (sector erase) covers the aligned block of 2^cmd_sec_lg bytes that holds cmd_addr. If cmd_sec_lg is larger than the address width, the block is the whole memory. The erase is rejected if any byte of that block is protected.
- R9: cmd_kind 2'b10 (whole-memory erase) is rejected whenever open = 0 and accepted when open = 1.
- R10: cmd_kind 2'b11 is reserved and always rejected.
- R11: Every rejected command sets the violation flag. The flag appears on prot_viol and at address 1, bit 0. After the load, writing 1 to address 1 bit 0 clears the flag, and writing 0 leaves it unchanged. A rejection in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Protection configuration byte fetched from program memory |
| cfg_dbe | input | 1 | Uncorrectable-error flag for cfg_byte |
| cfg_done | input | 1 | Load-done strobe of the reset sequence |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 1 | Register select: 0 protection, 1 violation flag |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| cmd_valid | input | 1 | Command present for one cycle |
| cmd_kind | input | 2 | 00 program, 01 sector erase, 10 whole erase, 11 reserved |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_sec_lg | input | 4 | log2 of the sector size in bytes |
| res_valid | output | 1 | Result present, one cycle after cmd_valid |
| res_ok | output | 1 | 1 accept, 0 reject |
| prot_viol | output | 1 | Sticky protection-violation flag |

## Verification
Faults in this block show up as wrong values at the ports. A wrong write filter shows in the register readback in the cycle after the write, so the bench sweeps every loaded value against every written value. A wrong boundary in the window decode shows as a wrong accept on res_ok one cycle after a command placed next to the boundary, so the bench walks program and sector-erase addresses across every size setting. A flag that does not stick, or that clears too easily, shows on prot_viol in the cycle after a rejection or a clear write.

// File: rtl/nvm_prot_pkg.sv
package nvm_prot_pkg;

    // width of the protection-size field; fixed by the register layout
    localparam int SIZE_W = 5;
    // width of the log2 sector-size input
    localparam int LG_W   = 4;

    typedef enum logic [1:0] {
        CMD_PROG    = 2'b00,
        CMD_ERS_SEC = 2'b01,
        CMD_ERS_ALL = 2'b10,
        CMD_RSVD    = 2'b11
    } cmd_kind_e;

    typedef struct packed {
        logic              open;
        logic [SIZE_W-1:0] size;
    } prot_cfg_t;

    localparam prot_cfg_t PROT_FULL = '{open: 1'b0, size: '1};

endpackage

// File: rtl/nvm_prot_regfile.sv
module nvm_prot_regfile
    import nvm_prot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [7:0] cfg_byte,
    input  logic      cfg_dbe,
    input  logic      cfg_done,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    output prot_cfg_t cfg_q,
    output logic      loaded_q
);

    typedef struct packed {
        prot_cfg_t cfg;
        logic      loaded;
    } rf_state_t;

    rf_state_t st_d, st_q;

    prot_cfg_t         boot_cfg;
    logic [SIZE_W-1:0] wr_size;
    logic              wr_open;
    logic              unused_bits;

    assign unused_bits = ^{cfg_byte[6:SIZE_W], wr_data[6:SIZE_W]};

    assign wr_size = wr_data[SIZE_W-1:0];
    assign wr_open = wr_data[7];

    always_comb begin
        boot_cfg.open = cfg_byte[7];
        boot_cfg.size = cfg_byte[SIZE_W-1:0];
        if (cfg_dbe) begin
            boot_cfg = PROT_FULL;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.loaded) begin
            if (cfg_done) begin
                st_d.loaded = 1'b1;
                st_d.cfg    = boot_cfg;
            end
        end else if (wr_en) begin
            // protection may only be added
            st_d.cfg.open = st_q.cfg.open & wr_open;
            if (wr_size > st_q.cfg.size) begin
                st_d.cfg.size = wr_size;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg    <= PROT_FULL;
            st_q.loaded <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q    = st_q.cfg;
    assign loaded_q = st_q.loaded;

endmodule

// File: rtl/nvm_prot_range.sv
module nvm_prot_range
    import nvm_prot_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int GRAN_BYTES = 64
) (
    input  prot_cfg_t              cfg,
    output logic                   prot_en,
    output logic [$clog2(MEM_BYTES):0] prot_lo
);

    localparam int ADDR_W  = $clog2(MEM_BYTES);
    localparam int GRAN_LG = $clog2(GRAN_BYTES);
    localparam int RAW_W   = SIZE_W + GRAN_LG + 1;
    localparam int CALC_W  = (RAW_W > ADDR_W + 1) ? RAW_W : ADDR_W + 1;

    logic [CALC_W-1:0] span;
    logic [CALC_W-1:0] capped;
    logic [CALC_W-1:0] low_full;
    logic              unused_hi;

    always_comb begin
        span = (CALC_W'(cfg.size) + CALC_W'(1)) << GRAN_LG;
        if (span > CALC_W'(MEM_BYTES)) begin
            capped = CALC_W'(MEM_BYTES);
        end else begin
            capped = span;
        end
        low_full = CALC_W'(MEM_BYTES) - capped;
    end

    generate
        if (CALC_W > ADDR_W + 1) begin : g_trim
            assign unused_hi = ^low_full[CALC_W-1:ADDR_W+1];
        end else begin : g_fit
            assign unused_hi = 1'b0;
        end
    endgenerate

    assign prot_lo = low_full[ADDR_W:0];
    assign prot_en = ~cfg.open;

endmodule

// File: rtl/nvm_prot_check.sv
module nvm_prot_check
    import nvm_prot_pkg::*;
#(
    parameter int MEM_BYTES = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_kind,
    input  logic [$clog2(MEM_BYTES)-1:0] cmd_addr,
    input  logic [LG_W-1:0]          cmd_sec_lg,
    input  logic                     prot_en,
    input  logic [$clog2(MEM_BYTES):0] prot_lo,
    input  logic                     clr_req,
    output logic                     res_valid,
    output logic                     res_ok,
    output logic                     viol
);

    localparam int ADDR_W = $clog2(MEM_BYTES);

    typedef struct packed {
        logic res_valid;
        logic res_ok;
        logic viol;
    } ck_state_t;

    ck_state_t st_d, st_q;

    cmd_kind_e         kind;
    logic [LG_W-1:0]   lg_eff;
    logic [ADDR_W:0]   sec_mask;
    logic [ADDR_W:0]   addr_ext;
    logic [ADDR_W:0]   sec_last;
    logic              byte_hit;
    logic              sec_hit;
    logic              allow;

    assign kind     = cmd_kind_e'(cmd_kind);
    assign lg_eff   = (cmd_sec_lg > LG_W'(ADDR_W)) ? LG_W'(ADDR_W) : cmd_sec_lg;
    assign addr_ext = {1'b0, cmd_addr};

    // low bits of the address covered by one sector
    generate
        for (genvar i = 0; i <= ADDR_W; i++) begin : g_mask
            assign sec_mask[i] = (lg_eff > LG_W'(i));
        end
    endgenerate

    assign sec_last = addr_ext | sec_mask;
    assign byte_hit = prot_en && (addr_ext >= prot_lo);
    assign sec_hit  = prot_en && (sec_last >= prot_lo);

    always_comb begin
        case (kind)
            CMD_PROG:    allow = ~byte_hit;
            CMD_ERS_SEC: allow = ~sec_hit;
            CMD_ERS_ALL: allow = ~prot_en;
            default:     allow = 1'b0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = cmd_valid;
        st_d.res_ok    = cmd_valid & allow;
        if (cmd_valid && !allow) begin
            st_d.viol = 1'b1;
        end else if (clr_req) begin
            st_d.viol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_ok    = st_q.res_ok;
    assign viol      = st_q.viol;

endmodule

// File: rtl/nvm_prot_guard.sv
module nvm_prot_guard
    import nvm_prot_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int GRAN_BYTES = 64,
    localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte,
    input  logic              cfg_dbe,
    input  logic              cfg_done,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [3:0]        cmd_sec_lg,
    output logic              res_valid,
    output logic              res_ok,
    output logic              prot_viol
);

    prot_cfg_t         cur_cfg;
    logic              loaded;
    logic              prot_open;
    logic [SIZE_W-1:0] prot_size;
    logic              prot_en;
    logic [ADDR_W:0]   prot_lo;
    logic              cfg_wr;
    logic              clr_req;

    assign cfg_wr  = bus_wr && !bus_addr && loaded;
    assign clr_req = bus_wr &&  bus_addr && loaded && bus_wdata[0];

    nvm_prot_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_byte (cfg_byte),
        .cfg_dbe  (cfg_dbe),
        .cfg_done (cfg_done),
        .wr_en    (cfg_wr),
        .wr_data  (bus_wdata),
        .cfg_q    (cur_cfg),
        .loaded_q (loaded)
    );

    assign prot_open = cur_cfg.open;
    assign prot_size = cur_cfg.size;

    nvm_prot_range #(
        .MEM_BYTES  (MEM_BYTES),
        .GRAN_BYTES (GRAN_BYTES)
    ) u_range (
        .cfg     (cur_cfg),
        .prot_en (prot_en),
        .prot_lo (prot_lo)
    );

    nvm_prot_check #(
        .MEM_BYTES (MEM_BYTES)
    ) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_addr   (cmd_addr),
        .cmd_sec_lg (cmd_sec_lg),
        .prot_en    (prot_en),
        .prot_lo    (prot_lo),
        .clr_req    (clr_req),
        .res_valid  (res_valid),
        .res_ok     (res_ok),
        .viol       (prot_viol)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[7]        = prot_open;
            bus_rdata[SIZE_W-1:0] = prot_size;
        end else begin
            bus_rdata[0] = prot_viol;
        end
    end

endmodule

// File: rtl/nvm_prot_guard_chk.sv
module nvm_prot_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loaded,
    input logic       prot_open,
    input logic [4:0] prot_size,
    input logic       clr_req,
    input logic       bus_addr,
    input logic [7:0] bus_rdata,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic       res_valid,
    input logic       res_ok,
    input logic       prot_viol
);

    // R1
    preload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> (!prot_open && prot_size == 5'h1f));

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> bus_rdata[6:5] == 2'b00);

    // R4
    no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loaded) && !$past(prot_open)) |-> !prot_open);

    // R5
    no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loaded) |-> prot_size >= $past(prot_size));

    // R7
    res_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> res_valid);

    // R7
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !res_valid);

    // R9
    all_erase_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b10 && !prot_open) |=> !res_ok);

    // R10
    rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b11) |=> !res_ok);

    // R11
    reject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> prot_viol);

    // R11
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prot_viol) && !$past(clr_req)) |-> prot_viol);

endmodule

bind nvm_prot_guard nvm_prot_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loaded    (loaded),
    .prot_open (prot_open),
    .prot_size (prot_size),
    .clr_req   (clr_req),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .prot_viol (prot_viol)
);

// File: tb/nvm_prot_guard_bench.sv
`timescale 1ns/1ps
module nvm_prot_guard_bench;

    localparam int MEM  = 1024;
    localparam int GRAN = 64;
    localparam int AW   = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg_byte = '0;
    logic          cfg_dbe = 1'b0;
    logic          cfg_done = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_addr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [3:0]    cmd_sec_lg = '0;
    logic          res_valid;
    logic          res_ok;
    logic          prot_viol;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    nvm_prot_guard #(.MEM_BYTES(MEM), .GRAN_BYTES(GRAN)) u_nvm_prot_guard (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic boot(input logic [7:0] cfg, input logic dbe);
        rst_n = 1'b0;
        cmd_valid = 1'b0; bus_wr = 1'b0; cfg_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_byte = cfg; cfg_dbe = dbe; cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0; cfg_dbe = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cmd(input logic [1:0] k, input int a, input int lg, output logic ok);
        cmd_kind = k; cmd_addr = AW'(a); cmd_sec_lg = 4'(lg); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        ok = res_ok;
        check(res_valid === 1'b1, "R7 res_valid", int'(res_valid), 1);
    endtask

    function automatic int low_bound(input int o, input int s);
        int span;
        if (o != 0) return MEM;
        span = (s + 1) * GRAN;
        if (span > MEM) span = MEM;
        return MEM - span;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic ok;
        int lo;

        // R1: state before load-done
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, d);
        check(d == 8'h1f, "R1 preload read", d, 8'h1f);
        wr(1'b0, 8'h80);
        rd(1'b0, d);
        check(d == 8'h1f, "R1 preload write ignored", d, 8'h1f);
        cmd(2'b00, 0, 0, ok);
        check(ok == 1'b0 && prot_viol, "R1 preload reject", int'(ok), 0);
        wr(1'b1, 8'h01);
        rd(1'b1, d);
        check(d == 8'h01, "R1 preload clear ignored", d, 8'h01);

        // R2: load sweep with reserved bits set in the source byte
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 32; s++) begin
                boot(8'((o << 7) | 8'h60 | s), 1'b0);
                rd(1'b0, d);
                check(d == 8'((o << 7) | s), "R2 load", d, (o << 7) | s);
            end
        end
        boot(8'h83, 1'b0);
        cfg_byte = 8'h1e; cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        rd(1'b0, d);
        check(d == 8'h83, "R2 second strobe ignored", d, 8'h83);

        // R3: uncorrectable error on the load
        for (int c = 0; c < 256; c += 37) begin
            boot(8'(c), 1'b1);
            rd(1'b0, d);
            check(d == 8'h1f, "R3 error forces full", d, 8'h1f);
        end

        // R4, R5: every loaded value against every written value
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 32; s++) begin
                for (int wo = 0; wo < 2; wo++) begin
                    for (int ws = 0; ws < 32; ws++) begin
                        int exp;
                        boot(8'((o << 7) | s), 1'b0);
                        wr(1'b0, 8'((wo << 7) | 8'h60 | ws));
                        rd(1'b0, d);
                        exp = ((o & wo) << 7) | ((ws > s) ? ws : s);
                        check(d == 8'(exp), "R4 R5 filtered write", d, exp);
                    end
                end
            end
        end

        // R6, R7, R9: program and whole erase across every setting
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 32; s++) begin
                boot(8'((o << 7) | s), 1'b0);
                lo = low_bound(o, s);
                for (int a = 0; a < MEM; a += 8) begin
                    bit exp_ok;
                    exp_ok = !(a >= lo);
                    cmd(2'b00, a, 0, ok);
                    check(ok == exp_ok, "R6 R7 program", int'(ok), int'(exp_ok));
                    if (!ok) begin
                        check(prot_viol == 1'b1, "R11 flag set", int'(prot_viol), 1);
                        wr(1'b1, 8'h01);
                    end
                end
                cmd(2'b10, 0, 0, ok);
                check(ok == (o != 0), "R9 whole erase", int'(ok), o);
                if (!ok) wr(1'b1, 8'h01);
            end
        end

        // R8: sector erase including oversized sector codes
        for (int s = 0; s < 32; s += 5) begin
            boot(8'(s), 1'b0);
            lo = low_bound(0, s);
            for (int lg = 0; lg < 16; lg++) begin
                for (int a = 0; a < MEM; a += 40) begin
                    int le, last;
                    bit exp_ok;
                    le   = (lg > AW) ? AW : lg;
                    last = (a | ((1 << le) - 1));
                    exp_ok = !(last >= lo);
                    cmd(2'b01, a, lg, ok);
                    check(ok == exp_ok, "R8 sector erase", int'(ok), int'(exp_ok));
                    if (!ok) wr(1'b1, 8'h01);
                end
            end
        end
        boot(8'h80, 1'b0);
        cmd(2'b01, MEM - 1, 15, ok);
        check(ok == 1'b1, "R8 open sector erase", int'(ok), 1);

        // R10: reserved kind even with protection off
        cmd(2'b11, 0, 0, ok);
        check(ok == 1'b0, "R10 reserved kind", int'(ok), 0);

        // R11: flag behaviour
        check(prot_viol == 1'b1, "R11 set by reserved", int'(prot_viol), 1);
        wr(1'b1, 8'hfe);
        rd(1'b1, d);
        check(d == 8'h01, "R11 write 0 no effect", d, 8'h01);
        wr(1'b1, 8'h01);
        rd(1'b1, d);
        check(d == 8'h00, "R11 clear", d, 8'h00);
        bus_addr = 1'b1; bus_wdata = 8'h01; bus_wr = 1'b1;
        cmd_kind = 2'b11; cmd_valid = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cmd_valid = 1'b0;
        check(prot_viol == 1'b1, "R11 set wins over clear", int'(prot_viol), 1);
        @(negedge clk);
        check(res_valid == 1'b0, "R7 single result", int'(res_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule